// File: doc/BRIEF.md
# Word Load/Store Lane Aligner

This block sits between a load/store unit and a 64-bit memory data bus. It places 32-bit word accesses on the bus. Each request carries the low three bits of the virtual address, the already-translated physical address, a store/load flag and the 32-bit store word. The request stage checks word alignment and sets the lane from the address offset and the CPU endianness. It adjusts physical address bit 2 when the reverse-endian mode is on. For an aligned access it then issues a word-sized memory request with a byte-enable mask, shifted write data and the selected lane. A misaligned access raises a load or store address-error exception in place of the memory request.

A second path takes the 64-bit data the memory returns, along with the lane bit echoed from the request. It picks the 32-bit word from that lane and returns it sign-extended to 64 bits. Address translation, caching and the memory itself are outside the block.

Both paths are valid/ready streams with one register stage each. A beat moves on any rising clock edge where valid and ready are both high. `in_ready` is high whenever the request output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, every request output holds its value and no new request is taken. The load path follows the same rule, with `rd_ready = !ld_valid || ld_ready`.

Top module: `word_lane_aligner`

## Requirements
- R1: A request with `in_voff[1:0] != 0` is misaligned. Its output beat has `out_req` = 0, `out_be` = 0 and `out_wdata` = 0. It has `out_exc_load` = 1 for a load (`in_store` = 0) or `out_exc_store` = 1 for a store, never both. An aligned beat has both exception bits at 0 and `out_req` = 1.
- R2: `out_paddr` equals `in_paddr` with bit 2 inverted when `cfg_rev_end` = 1, and unchanged otherwise. All other bits pass through unchanged.
- R3: The lane bit is `out_lane_hi = in_voff[2] ^ cfg_big_end`. On an issued access, `out_be` is 8'hF0 when the lane is high and 8'h0F when it is low. Bit n of `out_be` enables bus byte n, meaning bits [8n+7:8n].
- R4: On an issued access, `out_wdata` carries the store word shifted left by 32 bits when the lane is high, and unshifted when it is low. The other half of the bus is zero.
- R5: The load path returns `ld_data` = the word `rd_data[63:32]` when `rd_lane_hi` = 1, or `rd_data[31:0]` otherwise. The word is sign-extended from its bit 31 to 64 bits.
- R6: Every request beat carries `out_size` = 2'd2, the word code in the encoding 0 byte, 1 halfword, 2 word, 3 doubleword.
- R7: Outputs are registered. `out_valid` rises on the clock edge that accepts a request and not before. A lone beat leaves on the next edge while `out_ready` is high. The load path has the same one-cycle latency.
- R8: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and every request output is held.
- R9: While `ld_valid` = 1 and `ld_ready` = 0, `rd_ready` is 0 and `ld_data` is held.
- R10: During and right after reset, `out_valid` and `ld_valid` are 0 and both ready outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_store | input | 1 | 1 = store, 0 = load |
| in_voff | input | 3 | Low three bits of the virtual address |
| in_paddr | input | PA_W | Translated physical address |
| in_sdata | input | WORD_W | Store word |
| cfg_big_end | input | 1 | CPU big-endian mode |
| cfg_rev_end | input | 1 | Reverse-endian mode |
| out_valid | output | 1 | Request beat valid |
| out_ready | input | 1 | Downstream accepts request beat |
| out_req | output | 1 | Memory access issued on this beat |
| out_store | output | 1 | Beat is a store |
| out_exc_load | output | 1 | Load address-error exception |
| out_exc_store | output | 1 | Store address-error exception |
| out_paddr | output | PA_W | Adjusted physical address |
| out_size | output | 2 | Access size code (word = 2) |
| out_be | output | 2*WORD_W/8 | Byte-enable mask |
| out_lane_hi | output | 1 | Selected lane is the upper half of the bus |
| out_wdata | output | 2*WORD_W | Bus write data |
| rd_valid | input | 1 | Returned load data valid |
| rd_ready | output | 1 | Returned load data accepted |
| rd_data | input | 2*WORD_W | Returned bus data |
| rd_lane_hi | input | 1 | Lane bit echoed with returned data |
| ld_valid | output | 1 | Load result valid |
| ld_ready | input | 1 | Consumer accepts load result |
| ld_data | output | 2*WORD_W | Sign-extended load word |

## Verification
Random requests mix all four offsets with both endianness controls. This covers the case where big-endian mode and address bit 2 cancel, where a design that ignored either one would pick the wrong lane, byte mask and data shift. Offsets 1, 2 and 3 hit each misaligned pattern. A design that tested only bit 0, or let an exception leak a strobe or byte mask, would issue a memory access for a faulting address. The reverse-endian bit is toggled on its own to catch a design that flips the wrong address bit or ties the flip to the CPU endianness. Loaded words with bit 31 set and clear in both lanes expose zero-extension or a wrong sign bit. Stalls on each output show whether a register stage overwrites a held beat or keeps accepting input.

// File: rtl/wla_pkg.sv
package wla_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/wla_addr_map.sv
module wla_addr_map #(
  parameter int PA_W   = 36,
  parameter int WORD_W = 32,
  localparam int BUS_W = 2 * WORD_W,
  localparam int NB    = BUS_W / 8
) (
  input  logic              is_store,
  input  logic [2:0]        voff,
  input  logic [PA_W-1:0]   paddr,
  input  logic [WORD_W-1:0] sdata,
  input  logic              big_end,
  input  logic              rev_end,
  output logic              issue,
  output logic              exc_load,
  output logic              exc_store,
  output logic [PA_W-1:0]   paddr_adj,
  output logic              lane_hi,
  output logic [NB-1:0]     be,
  output logic [BUS_W-1:0]  wdata
);
  logic misalign;

  always_comb begin
    misalign  = |voff[1:0];
    issue     = !misalign;
    exc_load  = misalign && !is_store;
    exc_store = misalign && is_store;
    lane_hi   = voff[2] ^ big_end;
    paddr_adj = paddr;
    paddr_adj[2] = paddr[2] ^ rev_end;
    if (!misalign)
      wdata = lane_hi ? {sdata, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, sdata};
    else
      wdata = '0;
  end

  for (genvar b = 0; b < NB; b++) begin : g_be
    assign be[b] = issue && ((b >= NB / 2) == lane_hi);
  end
endmodule

// File: rtl/wla_req_stage.sv
module wla_req_stage #(
  parameter int PA_W   = 36,
  parameter int WORD_W = 32,
  localparam int BUS_W = 2 * WORD_W,
  localparam int NB    = BUS_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              d_issue,
  input  logic              d_store,
  input  logic              d_exc_load,
  input  logic              d_exc_store,
  input  logic [PA_W-1:0]   d_paddr,
  input  logic              d_lane_hi,
  input  logic [NB-1:0]     d_be,
  input  logic [BUS_W-1:0]  d_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_req,
  output logic              out_store,
  output logic              out_exc_load,
  output logic              out_exc_store,
  output logic [PA_W-1:0]   out_paddr,
  output logic [1:0]        out_size,
  output logic [NB-1:0]     out_be,
  output logic              out_lane_hi,
  output logic [BUS_W-1:0]  out_wdata
);
  import wla_pkg::*;

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_req       <= 1'b0;
      out_store     <= 1'b0;
      out_exc_load  <= 1'b0;
      out_exc_store <= 1'b0;
      out_paddr     <= '0;
      out_size      <= 2'd0;
      out_be        <= '0;
      out_lane_hi   <= 1'b0;
      out_wdata     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_req       <= d_issue;
        out_store     <= d_store;
        out_exc_load  <= d_exc_load;
        out_exc_store <= d_exc_store;
        out_paddr     <= d_paddr;
        out_size      <= SZ_WORD;
        out_be        <= d_be;
        out_lane_hi   <= d_lane_hi;
        out_wdata     <= d_wdata;
      end
    end
  end

  // R1
  exc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_exc_load, out_exc_store}));
  // R1
  exc_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_exc_load || out_exc_store)) |-> (!out_req && out_be == '0));
  // R3
  be_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_req) |-> ($countones(out_be) == NB / 2));
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_paddr) &&
                                   $stable(out_wdata) && $stable(out_be)));
endmodule

// File: rtl/wla_load_extract.sv
module wla_load_extract #(
  parameter int WORD_W = 32,
  localparam int BUS_W = 2 * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [BUS_W-1:0] rd_data,
  input  logic             rd_lane_hi,
  output logic             ld_valid,
  input  logic             ld_ready,
  output logic [BUS_W-1:0] ld_data
);
  logic [WORD_W-1:0] word;
  logic [BUS_W-1:0]  sext;

  assign rd_ready = !ld_valid || ld_ready;

  always_comb begin
    word = rd_lane_hi ? rd_data[BUS_W-1:WORD_W] : rd_data[WORD_W-1:0];
    sext = {{WORD_W{word[WORD_W-1]}}, word};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else if (rd_ready) begin
      ld_valid <= rd_valid;
      if (rd_valid) ld_data <= sext;
    end
  end

  // R5
  ld_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (ld_data[BUS_W-1:WORD_W] == {WORD_W{ld_data[WORD_W-1]}}));
  // R9
  ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready) |=> (ld_valid && $stable(ld_data)));
endmodule

// File: rtl/word_lane_aligner.sv
module word_lane_aligner #(
  parameter int PA_W   = 36,
  parameter int WORD_W = 32,
  localparam int BUS_W = 2 * WORD_W,
  localparam int NB    = BUS_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_store,
  input  logic [2:0]        in_voff,
  input  logic [PA_W-1:0]   in_paddr,
  input  logic [WORD_W-1:0] in_sdata,
  input  logic              cfg_big_end,
  input  logic              cfg_rev_end,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_req,
  output logic              out_store,
  output logic              out_exc_load,
  output logic              out_exc_store,
  output logic [PA_W-1:0]   out_paddr,
  output logic [1:0]        out_size,
  output logic [NB-1:0]     out_be,
  output logic              out_lane_hi,
  output logic [BUS_W-1:0]  out_wdata,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [BUS_W-1:0]  rd_data,
  input  logic              rd_lane_hi,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [BUS_W-1:0]  ld_data
);
  logic              m_issue, m_exc_ld, m_exc_st, m_lane;
  logic [PA_W-1:0]   m_paddr;
  logic [NB-1:0]     m_be;
  logic [BUS_W-1:0]  m_wdata;

  wla_addr_map #(.PA_W(PA_W), .WORD_W(WORD_W)) u_map (
    .is_store(in_store), .voff(in_voff), .paddr(in_paddr), .sdata(in_sdata),
    .big_end(cfg_big_end), .rev_end(cfg_rev_end),
    .issue(m_issue), .exc_load(m_exc_ld), .exc_store(m_exc_st),
    .paddr_adj(m_paddr), .lane_hi(m_lane), .be(m_be), .wdata(m_wdata)
  );

  wla_req_stage #(.PA_W(PA_W), .WORD_W(WORD_W)) u_req (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d_issue(m_issue), .d_store(in_store), .d_exc_load(m_exc_ld),
    .d_exc_store(m_exc_st), .d_paddr(m_paddr), .d_lane_hi(m_lane),
    .d_be(m_be), .d_wdata(m_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_req(out_req),
    .out_store(out_store), .out_exc_load(out_exc_load),
    .out_exc_store(out_exc_store), .out_paddr(out_paddr),
    .out_size(out_size), .out_be(out_be), .out_lane_hi(out_lane_hi),
    .out_wdata(out_wdata)
  );

  wla_load_extract #(.WORD_W(WORD_W)) u_ld (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_lane_hi(rd_lane_hi),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data)
  );
endmodule

// File: tb/sim_word_lane_aligner.sv
`timescale 1ns/1ps
module sim_word_lane_aligner;
  localparam int PA_W = 36;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_store = 0, cfg_big_end = 0, cfg_rev_end = 0;
  logic [2:0] in_voff = '0;
  logic [PA_W-1:0] in_paddr = '0;
  logic [31:0] in_sdata = '0;
  logic out_ready = 1, rd_valid = 0, rd_lane_hi = 0, ld_ready = 1;
  logic [63:0] rd_data = '0;
  logic in_ready, out_valid, out_req, out_store, out_exc_load, out_exc_store;
  logic [PA_W-1:0] out_paddr;
  logic [1:0] out_size;
  logic [7:0] out_be;
  logic out_lane_hi, rd_ready, ld_valid;
  logic [63:0] out_wdata, ld_data;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  word_lane_aligner #(.PA_W(PA_W), .WORD_W(32)) u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic e_lane(input logic [2:0] v, input logic big);
    return v[2] ^ big;
  endfunction
  function automatic logic [PA_W-1:0] e_paddr(input logic [PA_W-1:0] p, input logic rev);
    logic [PA_W-1:0] r = p;
    r[2] = p[2] ^ rev;
    return r;
  endfunction
  function automatic logic [63:0] e_ld(input logic [63:0] d, input logic hi);
    logic [31:0] w = hi ? d[63:32] : d[31:0];
    return {{32{w[31]}}, w};
  endfunction

  task automatic send(input logic st, input logic [2:0] v, input logic [PA_W-1:0] p,
                      input logic [31:0] sd, input logic big, input logic rev);
    logic mis, ln;
    @(negedge clk);
    in_valid = 1; in_store = st; in_voff = v; in_paddr = p; in_sdata = sd;
    cfg_big_end = big; cfg_rev_end = rev;
    chk("R7 not before edge", {63'b0, out_valid}, 64'd0);
    @(negedge clk);
    in_valid = 0;
    mis = |v[1:0];
    ln  = e_lane(v, big);
    chk("R7 valid", {63'b0, out_valid}, 64'd1);
    chk("R1 req", {63'b0, out_req}, {63'b0, !mis});
    chk("R1 exc_load", {63'b0, out_exc_load}, {63'b0, mis && !st});
    chk("R1 exc_store", {63'b0, out_exc_store}, {63'b0, mis && st});
    chk("R6 size", {62'b0, out_size}, 64'd2);
    if (mis) begin
      chk("R1 be", {56'b0, out_be}, 64'd0);
      chk("R1 wdata", out_wdata, 64'd0);
    end else begin
      chk("R2 paddr", 64'(out_paddr), 64'(e_paddr(p, rev)));
      chk("R3 lane", {63'b0, out_lane_hi}, {63'b0, ln});
      chk("R3 be", {56'b0, out_be}, ln ? 64'hF0 : 64'h0F);
      chk("R4 wdata", out_wdata, ln ? {sd, 32'h0} : {32'h0, sd});
    end
  endtask

  task automatic load(input logic [63:0] d, input logic hi);
    @(negedge clk);
    rd_valid = 1; rd_data = d; rd_lane_hi = hi;
    @(negedge clk);
    rd_valid = 0;
    chk("R7 ld valid", {63'b0, ld_valid}, 64'd1);
    chk("R5 ld data", ld_data, e_ld(d, hi));
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk("R10 out_valid", {63'b0, out_valid}, 64'd0);
    chk("R10 ld_valid", {63'b0, ld_valid}, 64'd0);
    chk("R10 in_ready", {63'b0, in_ready}, 64'd1);
    rst_n = 1;
    @(negedge clk);
    chk("R10 rd_ready", {63'b0, rd_ready}, 64'd1);

    // directed corners: every offset, both endians, both reverse modes
    for (int v = 0; v < 8; v++)
      for (int m = 0; m < 4; m++) begin
        send(v[0], 3'(v), 36'h9_8765_4321, 32'hA5C3_0F11, m[0], m[1]);
        send(!v[0], 3'(v), 36'h0_0000_0004, 32'h8000_0001, m[0], m[1]);
      end
    // R7: lone beat drains on next edge
    @(negedge clk);
    chk("R7 drain", {63'b0, out_valid}, 64'd0);

    load(64'h8000_0000_7FFF_FFFF, 1'b1);
    load(64'h8000_0000_7FFF_FFFF, 1'b0);
    load(64'h1234_5678_9ABC_DEF0, 1'b0);
    load(64'h1234_5678_9ABC_DEF0, 1'b1);

    for (int i = 0; i < 400; i++) begin
      send(1'($urandom()), 3'($urandom()), 36'({$urandom(), $urandom()}),
           $urandom(), 1'($urandom()), 1'($urandom()));
      load({$urandom(), $urandom()}, 1'($urandom()));
    end

    // R8: back-pressure on request output
    @(negedge clk);
    out_ready = 0;
    in_valid = 1; in_store = 1; in_voff = 3'd4; in_paddr = 36'h1_0000_0010;
    in_sdata = 32'hDEAD_BEEF; cfg_big_end = 0; cfg_rev_end = 0;
    @(negedge clk);
    in_voff = 3'd0; in_paddr = 36'h2_0000_0020; in_sdata = 32'h0BAD_F00D;
    for (int k = 0; k < 3; k++) begin
      chk("R8 in_ready low", {63'b0, in_ready}, 64'd0);
      chk("R8 paddr held", 64'(out_paddr), 64'h1_0000_0010);
      chk("R8 wdata held", out_wdata, 64'hDEAD_BEEF_0000_0000);
      @(negedge clk);
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R8 next beat", out_wdata, 64'h0000_0000_0BAD_F00D);
    chk("R8 next paddr", 64'(out_paddr), 64'h2_0000_0020);
    @(negedge clk);

    // R9: back-pressure on load output
    ld_ready = 0;
    rd_valid = 1; rd_data = 64'hFFFF_0000_0000_1234; rd_lane_hi = 1;
    @(negedge clk);
    rd_data = 64'h0; rd_lane_hi = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R9 rd_ready low", {63'b0, rd_ready}, 64'd0);
      chk("R9 ld held", ld_data, 64'hFFFF_FFFF_FFFF_0000);
      @(negedge clk);
    end
    ld_ready = 1;
    @(negedge clk);
    rd_valid = 0;
    chk("R9 next ld", ld_data, 64'd0);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule